// File: doc/BRIEF.md
# Seat Belt Alarm Controller

This block is a synchronous three-state controller that watches an ignition key and a seat belt sensor and drives an alarm. When the key is turned on, the controller begins waiting and starts an internal elapsed-time counter. If the belt is not fastened within a warning interval, the alarm sounds. It stays on until the belt is fastened, the key is turned off, or a cutoff interval has passed. Both intervals are measured from the same start.

Time is kept by a prescaler of `CYCLES_PER_SEC` clock cycles feeding a saturating seconds counter. The warning and cutoff limits are whole seconds set by parameters, so a bench can use short values. The four event inputs are sampled as levels on every clock. An input that has no meaning in the current state is treated as absent, and the state holds.

Contradictory readings are resolved in the conservative direction. A key-off that arrives together with a key-on cancels the key-on. A belt that reads fastened and unfastened in the same cycle does not count as fastened.

Top module: `seat_belt_alarm`

## Requirements
- R1: While the active-low synchronous reset is low, and on the first cycle after it, state_code is 00 (idle), alarm is 0 and timer_start is 0, whatever the event inputs do.
- R2: In idle (00), key_on high with key_off low moves the machine to waiting (01) on the next edge. timer_start is high for exactly that first waiting cycle, and the elapsed count restarts from zero at that edge.
- R3: In waiting (01), a belt event or a key_off event returns the machine to idle (00) on the next edge, and alarm stays 0. A belt event is belt_on high with belt_off low.
- R4: In waiting with no cancelling event, the machine enters alarm (10) at edge WARN_SEC*CYCLES_PER_SEC+1 counted from the start edge. The alarm output is high exactly while state_code is 10.
- R5: If a cancelling event arrives at the very edge at which the warning limit would move waiting to alarm, the machine goes to idle instead, and alarm never rises.
- R6: In alarm (10), a belt event or a key_off event returns the machine to idle on the next edge, and alarm falls at the same edge.
- R7: In alarm with no cancelling event, the machine returns to idle at edge CUTOFF_SEC*CYCLES_PER_SEC+1 counted from the start edge.
- R8: key_on seen in waiting or alarm is ignored. No timer_start pulse is produced, and the warning and cutoff times stay measured from the original start.
- R9: Inputs that are not listed for the current state leave the state unchanged. belt_off alone never causes a transition, belt_on and key_off do nothing in idle, and belt_on together with belt_off is no belt event.
- R10: In idle, key_on and key_off high together keep the machine in idle with no timer_start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_on | input | 1 | Ignition turned on |
| key_off | input | 1 | Ignition turned off |
| belt_on | input | 1 | Seat belt reads fastened |
| belt_off | input | 1 | Seat belt reads unfastened |
| alarm | output | 1 | Alarm level, registered |
| timer_start | output | 1 | One-cycle pulse when the elapsed count is started |
| state_code | output | 2 | Current state: 00 idle, 01 waiting, 10 alarm |

## Verification
The bench places a cancelling event exactly on the warning edge. A design that checked the threshold before the cancel would sound the alarm for one cycle there. It repeats key_on while waiting and while the alarm is on. A controller that restarted its count on those pulses would shift the alarm entry and the cutoff later and would pulse timer_start. Long idle stretches confirm the alarm ends exactly at the cutoff edge, where an off-by-one comparison or a counter that wraps would show up as an early, late or missing return to idle. Random mixes of simultaneous key and belt readings exercise the contradictory-input rules, which a design with the wrong priority would answer with a spurious start or cancel.

// File: rtl/sba_pkg.sv
// Shared types for the seat belt alarm controller.
// Assumes: state codes are visible at the top port and must stay fixed.
package sba_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_WAIT  = 2'b01,
        ST_ALARM = 2'b10,
        ST_BAD   = 2'b11
    } sba_state_e;

    // Decoded events after conflict resolution.
    typedef struct packed {
        logic arm;     // a key turn-on that is not cancelled by key-off
        logic cancel;  // key-off or a credible belt-fastened reading
    } sba_evt_t;

endpackage

// File: rtl/sba_evt_decode.sv
// Event decoder: turns the four raw level inputs into the two events the
// controller acts on. Key-off overrides key-on, and a belt that reads both
// fastened and unfastened is not credited as fastened.
// Assumes: inputs are already synchronous and debounced.
module sba_evt_decode
    import sba_pkg::*;
(
    input  logic     key_on,
    input  logic     key_off,
    input  logic     belt_on,
    input  logic     belt_off,
    output sba_evt_t evt
);

    logic belt_fastened;

    // Resolve contradictory readings and form the event pair.
    always_comb begin
        belt_fastened = belt_on & ~belt_off;
        evt.arm       = key_on & ~key_off;
        evt.cancel    = key_off | belt_fastened;
    end

endmodule

// File: rtl/sba_sec_timer.sv
// Elapsed-time counter: a prescaler of CYCLES_PER_SEC cycles drives a
// saturating seconds count. Restart clears both at the edge where it is
// high. Two threshold flags compare the registered seconds count.
// Assumes: CYCLES_PER_SEC >= 2 and WARN_SEC < CUTOFF_SEC.
module sba_sec_timer #(
    parameter int CYCLES_PER_SEC = 50_000_000,
    parameter int WARN_SEC       = 5,
    parameter int CUTOFF_SEC     = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic warn_hit,
    output logic cut_hit
);

    localparam int PW = (CYCLES_PER_SEC > 1) ? $clog2(CYCLES_PER_SEC) : 1;
    localparam int SW = $clog2(CUTOFF_SEC + 2);
    localparam logic [PW-1:0] PRE_LAST = PW'(CYCLES_PER_SEC - 1);
    localparam logic [SW-1:0] SEC_MAX  = {SW{1'b1}};

    logic [PW-1:0] pre_q;
    logic [SW-1:0] sec_q;

    // Prescaler: counts cycles within the current second.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Seconds count: advances on prescaler wrap, holds at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sec_q <= '0;
        end else if (pre_q == PRE_LAST && sec_q != SEC_MAX) begin
            sec_q <= sec_q + 1'b1;
        end
    end

    // Threshold flags taken from the registered count.
    always_comb begin
        warn_hit = (sec_q >= SW'(WARN_SEC));
        cut_hit  = (sec_q >= SW'(CUTOFF_SEC));
    end

endmodule

// File: rtl/sba_ctrl_fsm.sv
// Three-state controller. Idle arms on a key turn-on. Waiting cancels on a
// cancel event, otherwise it moves to alarm at the warning limit. Alarm ends
// on a cancel event or at the cutoff. The unused code recovers to idle.
// Assumes: warn_hit and cut_hit come from a count restarted by start_now.
module sba_ctrl_fsm
    import sba_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sba_evt_t   evt,
    input  logic       warn_hit,
    input  logic       cut_hit,
    output logic       start_now,
    output sba_state_e state_q,
    output logic       alarm_q,
    output logic       start_q
);

    sba_state_e state_d;

    // Next-state choice; cancel ranks above the warning limit in waiting.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (evt.arm) state_d = ST_WAIT;
            ST_WAIT:  begin
                if (evt.cancel)    state_d = ST_OFF;
                else if (warn_hit) state_d = ST_ALARM;
            end
            ST_ALARM: if (evt.cancel || cut_hit) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // Start of timing happens only on the idle-to-waiting step.
    always_comb begin
        start_now = (state_q == ST_OFF) && evt.arm;
    end

    // State register and registered Moore outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            alarm_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            alarm_q <= (state_d == ST_ALARM);
            start_q <= start_now;
        end
    end

endmodule

// File: rtl/seat_belt_alarm.sv
// Seat belt alarm controller top: event decoder, elapsed-time counter and
// three-state controller. Thresholds are whole seconds of CYCLES_PER_SEC.
// Assumes: inputs synchronous to clk; reset is synchronous and active low.
module seat_belt_alarm
    import sba_pkg::*;
#(
    parameter int CYCLES_PER_SEC = 50_000_000,
    parameter int WARN_SEC       = 5,
    parameter int CUTOFF_SEC     = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_on,
    input  logic       key_off,
    input  logic       belt_on,
    input  logic       belt_off,
    output logic       alarm,
    output logic       timer_start,
    output logic [1:0] state_code
);

    sba_evt_t   evt;
    logic       warn_hit;
    logic       cut_hit;
    logic       start_now;
    sba_state_e state_q;

    sba_evt_decode u_dec (
        .key_on   (key_on),
        .key_off  (key_off),
        .belt_on  (belt_on),
        .belt_off (belt_off),
        .evt      (evt)
    );

    sba_sec_timer #(
        .CYCLES_PER_SEC (CYCLES_PER_SEC),
        .WARN_SEC       (WARN_SEC),
        .CUTOFF_SEC     (CUTOFF_SEC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (start_now),
        .warn_hit (warn_hit),
        .cut_hit  (cut_hit)
    );

    sba_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .warn_hit  (warn_hit),
        .cut_hit   (cut_hit),
        .start_now (start_now),
        .state_q   (state_q),
        .alarm_q   (alarm),
        .start_q   (timer_start)
    );

    // Expose the state as its two-bit code.
    always_comb begin
        state_code = state_q;
    end

endmodule

// File: rtl/sba_checker.sv
// Port-level properties of the seat belt alarm controller, bound to the top.
// Assumes: state codes 00 idle, 01 waiting, 10 alarm.
module sba_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       key_on,
    input logic       key_off,
    input logic       belt_on,
    input logic       belt_off,
    input logic       alarm,
    input logic       timer_start,
    input logic [1:0] state_code
);

    // R2: a start pulse only appears on the first waiting cycle after idle.
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        timer_start |-> (state_code == 2'b01 && $past(state_code) == 2'b00));

    // R3: a cancel event in waiting returns to idle.
    a_r3_wait_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b01 && (key_off || (belt_on && !belt_off)))
        |=> (state_code == 2'b00 && !alarm));

    // R4: the alarm rises only when leaving waiting.
    a_r4_alarm_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> ($past(state_code) == 2'b01 && state_code == 2'b10));

    // R4: the code 11 never appears at the port.
    a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_code != 2'b11);

    // R6: a cancel event in alarm silences it at the next edge.
    a_r6_alarm_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b10 && (key_off || (belt_on && !belt_off)))
        |=> (state_code == 2'b00 && !alarm));

    // R8: no start pulse follows a cycle spent outside idle.
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 2'b00) |=> !timer_start);

    // R10: key-on with key-off in idle stays idle.
    a_r10_key_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b00 && key_on && key_off) |=> (state_code == 2'b00 && !timer_start));

endmodule

bind seat_belt_alarm sba_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_on      (key_on),
    .key_off     (key_off),
    .belt_on     (belt_on),
    .belt_off    (belt_off),
    .alarm       (alarm),
    .timer_start (timer_start),
    .state_code  (state_code)
);

// File: tb/sim_seat_belt_alarm.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random events, checked every
// cycle against a model written from the requirements.
module sim_seat_belt_alarm;

    localparam int CPS     = 3;
    localparam int WARN    = 2;
    localparam int CUT     = 4;
    localparam int WARN_CY = WARN * CPS;
    localparam int CUT_CY  = CUT * CPS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_on = 1'b0, key_off = 1'b0, belt_on = 1'b0, belt_off = 1'b0;
    logic       alarm, timer_start;
    logic [1:0] state_code;

    int  checks = 0;
    int  errors = 0;
    int  m_state = 0;
    int  m_cnt = 0;
    bit  m_ts = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    seat_belt_alarm #(
        .CYCLES_PER_SEC (CPS),
        .WARN_SEC       (WARN),
        .CUTOFF_SEC     (CUT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .key_on(key_on), .key_off(key_off),
        .belt_on(belt_on), .belt_off(belt_off), .alarm(alarm),
        .timer_start(timer_start), .state_code(state_code)
    );

    // Next state from the requirements; cnt is edges since the start edge.
    function automatic int model_next(int s, bit kon, bit kof, bit bon, bit bof, int cnt);
        bit cancel = kof || (bon && !bof);
        case (s)
            0: return (kon && !kof) ? 1 : 0;
            1: return cancel ? 0 : ((cnt >= WARN_CY) ? 2 : 1);
            2: return (cancel || cnt >= CUT_CY) ? 0 : 2;
            default: return 0;
        endcase
    endfunction

    // Name the requirement a transition exercises.
    function automatic string tag_of(int s, int ns, bit kon, bit kof, bit bon, bit bof, int cnt);
        bit cancel = kof || (bon && !bof);
        if (s == 0 && ns == 1) return "R2";
        if (s == 1 && ns == 0) return (cnt >= WARN_CY) ? "R5" : "R3";
        if (s == 1 && ns == 2) return "R4";
        if (s == 2 && ns == 0) return cancel ? "R6" : "R7";
        if (s != 0 && kon) return "R8";
        if (s == 0 && kon && kof) return "R10";
        return "R9";
    endfunction

    task automatic compare(string tag, int es, bit ea, bit et);
        checks++;
        if (state_code !== es[1:0] || alarm !== ea || timer_start !== et) begin
            errors++;
            $display("FAIL %s: state=%0d alarm=%0b start=%0b expected state=%0d alarm=%0b start=%0b",
                     tag, state_code, alarm, timer_start, es, ea, et);
        end
    endtask

    // One clock with the given inputs; entered and left at a falling edge.
    task automatic step(bit kon, bit kof, bit bon, bit bof);
        int    ns;
        string tag;
        key_on = kon; key_off = kof; belt_on = bon; belt_off = bof;
        @(posedge clk);
        #1;
        ns  = model_next(m_state, kon, kof, bon, bof, m_cnt);
        tag = tag_of(m_state, ns, kon, kof, bon, bof, m_cnt);
        m_ts = (m_state == 0 && ns == 1);
        if (m_ts) m_cnt = 0;
        else if (m_cnt < 100000) m_cnt = m_cnt + 1;
        m_state = ns;
        compare(tag, m_state, m_state == 2, m_ts);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd24601));
        // R1: reset holds idle even with key_on driven.
        key_on = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            compare("R1", 0, 1'b0, 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        key_on = 1'b0;
        step(1'b0, 1'b0, 1'b0, 1'b0);          // R1 first cycle after reset

        step(1'b1, 1'b1, 1'b0, 1'b0);          // R10 conflict in idle
        step(1'b0, 1'b0, 1'b0, 1'b1);          // R9 belt_off in idle
        step(1'b0, 1'b1, 1'b0, 0);             // R9 key_off in idle
        step(1'b0, 1'b0, 1'b1, 1'b0);          // R9 belt_on in idle

        step(1'b1, 1'b0, 1'b0, 1'b0);          // R2 start
        step(1'b0, 1'b0, 1'b1, 1'b1);          // R9 contradictory belt in waiting
        step(1'b0, 1'b0, 1'b0, 1'b1);          // R9 belt_off in waiting
        step(1'b0, 1'b0, 1'b1, 1'b0);          // R3 belt cancel

        step(1'b1, 1'b0, 1'b0, 1'b0);          // R2
        step(1'b0, 1'b1, 1'b0, 1'b0);          // R3 key-off cancel

        // R8 key_on repeated in waiting, then R4 entry and R6 belt cancel.
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < WARN_CY; i++) step(i[0], 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);          // R4 alarm entry, key_on ignored
        step(1'b1, 1'b0, 1'b0, 1'b0);          // R8 key_on during alarm
        step(1'b0, 1'b0, 1'b1, 1'b1);          // R9 contradictory belt in alarm
        step(1'b0, 1'b0, 1'b1, 1'b0);          // R6

        // R7 cutoff with key_on pulses during alarm.
        step(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < CUT_CY + 2; i++) step(i % 3 == 0, 1'b0, 1'b0, 1'b0);

        // R5 cancel exactly on the warning edge: belt, then key-off.
        step(1'b1, 1'b0, 1'b0, 1'b0);
        idle(WARN_CY);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0);
        idle(WARN_CY);
        step(1'b0, 1'b1, 1'b0, 1'b0);
        idle(2);

        // Random mix of events.
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 6) == 0, ($urandom % 20) == 0,
                 ($urandom % 16) == 0, ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule